// File: doc/BRIEF.md
# Receive/Transmit Queue Occupancy and DMA Handshake Flags

This block sits beside the 16-entry receive and transmit queues of an asynchronous serial port. It watches the push and pop strobes of both queues and keeps their fill levels internally. From those levels it produces the flags that the host and a DMA engine use to pace transfers: a receive-threshold interrupt, a data-available bit, a character-gap timeout, an overrun flag, and two active-low ready strobes. The queue storage, the shifters and the baud divider are outside the block.

The character-gap timeout is measured in ticks of the 16x oversampling enable. Its length is four times the current frame length: the start bit, 5 to 8 data bits, an optional parity bit, and one, one and a half or two stop bits. A frame-format change therefore changes the limit at once. The ready strobes follow one of two rules, picked by `dmaMode`. Mode 0 signals each character on its own. Mode 1 signals blocks, with the receive strobe held low until the queue drains.

The two flush inputs are single-cycle commands, so they clear themselves. Flushing the transmit queue clears only the transmit fill level. The transmit shifter is not touched.

Top module: `uart_fifo_flags`

## Requirements
- R1: `trigSel` picks the receive threshold: 00 = 1, 01 = 4, 10 = 8, 11 = 14 characters. `rxIrq` is high whenever the receive fill level is at or above the threshold and low below it.
- R2: `dataReady` goes high in the cycle after the first character is pushed and stays high until the receive queue is empty.
- R3: A receive push into a full queue (16 characters) with no pop sets `overrun`, and the fill level stays at 16. The flag stays set until a receive flush.
- R4: A push and a pop in the same cycle on a non-empty receive queue leave the fill level unchanged. A pop on an empty queue is ignored.
- R5: `rxTimeout` rises once the timeout counter reaches 4 × (16 × (1 + data bits + parity) + stop ticks). The counter advances once per `tick16`. `wordLen` 00..11 selects 5..8 data bits. `stopSel` 00 gives 16 stop ticks, 01 gives 24 and 1x gives 32.
- R6: The timeout counter restarts on `stopCentre` and on every receive pop. `rxTimeout` never asserts while the receive queue is empty.
- R7: With `dmaMode` = 0, `rxRdyN` is low whenever at least one received character is held and high when none are held.
- R8: With `dmaMode` = 1, `rxRdyN` goes low when the threshold is reached or a timeout occurs. It stays low, even after those causes go away, until the receive queue is empty.
- R9: With `dmaMode` = 0, `txRdyN` is low only while the transmit queue is empty.
- R10: With `dmaMode` = 1, `txRdyN` is low while any transmit location is free and high only when all 16 are occupied. A push into a full transmit queue is ignored.
- R11: `rxFlush` empties the receive queue and clears `overrun`. `txFlush` empties only the transmit queue and leaves the receive state alone.
- R12: After reset, both queues are empty, all flags are low, `rxRdyN` is high and `txRdyN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxPush | input | 1 | Character written into the receive queue |
| rxPop | input | 1 | Host read of the receive holding location |
| txPush | input | 1 | Host write into the transmit queue |
| txPop | input | 1 | Serialiser takes a character from the transmit queue |
| rxFlush | input | 1 | Receive queue reset command (one cycle) |
| txFlush | input | 1 | Transmit queue reset command (one cycle) |
| trigSel | input | 2 | Receive threshold selector |
| wordLen | input | 2 | Data bits: 00 = 5 to 11 = 8 |
| parityEn | input | 1 | Parity bit present in the frame |
| stopSel | input | 2 | Stop length: 00 = 1, 01 = 1.5, 1x = 2 bits |
| tick16 | input | 1 | 16x bit-clock enable |
| stopCentre | input | 1 | Pulse when the receiver samples the centre of a stop bit |
| dmaMode | input | 1 | Ready-strobe rule: 0 = per character, 1 = block |
| rxIrq | output | 1 | Receive threshold reached |
| dataReady | output | 1 | At least one received character held |
| rxTimeout | output | 1 | Character-gap timeout |
| overrun | output | 1 | Push into a full receive queue was lost |
| rxRdyN | output | 1 | Receive ready, active low |
| txRdyN | output | 1 | Transmit ready, active low |

## Verification
The fill levels are the only registers between a strobe and the level-based flags. `rxIrq`, `dataReady`, `overrun`, `txRdyN` and the mode-0 `rxRdyN` therefore change right after the clock edge that takes the strobe. The bench drives strobes at the falling edge and samples after the next rising edge.

The timeout counter is zero after the edge that takes `stopCentre` or a pop. It reaches the limit exactly that many ticked edges later. The bench checks `rxTimeout` one edge before the limit and again on it.

The sticky mode-1 receive strobe is latched one edge after its cause. The bench checks it only after a further edge, once the cause has gone.

// File: rtl/uart_flags_pkg.sv
package uart_flags_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic rxInc;
    logic rxDec;
    logic rxClr;
    logic ovrSet;
    logic ovrClr;
    logic txInc;
    logic txDec;
    logic txClr;
    logic tmoClr;
    logic tmoStep;
  } flag_strobes_t;

  // Receive threshold encoding; the order of levels is behaviour
  function automatic int unsigned trigLevel(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Ticks in one character: start + data + optional parity + stop
  function automatic int unsigned charTicks(input logic [1:0] wordLen,
                                            input logic       parityEn,
                                            input logic [1:0] stopSel,
                                            input int unsigned tpb);
    int unsigned bits;
    int unsigned stopTicks;
    bits = 6 + int'(wordLen) + (parityEn ? 1 : 0);
    case (stopSel)
      2'b00:   stopTicks = tpb;
      2'b01:   stopTicks = tpb + tpb / 2;
      default: stopTicks = 2 * tpb;
    endcase
    return tpb * bits + stopTicks;
  endfunction

endpackage

// File: rtl/uart_flags_dp.sv
module uart_flags_dp
  import uart_flags_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  flag_strobes_t    stb,
  output logic [CNT_W-1:0] rxCount,
  output logic [CNT_W-1:0] txCount,
  output logic [TMO_W-1:0] tmoCount,
  output logic             ovrFlag
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCount <= '0;
    end else if (stb.rxClr) begin
      rxCount <= '0;
    end else if (stb.rxInc && !stb.rxDec) begin
      rxCount <= rxCount + 1'b1;
    end else if (stb.rxDec && !stb.rxInc) begin
      rxCount <= rxCount - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCount <= '0;
    end else if (stb.txClr) begin
      txCount <= '0;
    end else if (stb.txInc && !stb.txDec) begin
      txCount <= txCount + 1'b1;
    end else if (stb.txDec && !stb.txInc) begin
      txCount <= txCount - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoCount <= '0;
    end else if (stb.tmoClr) begin
      tmoCount <= '0;
    end else if (stb.tmoStep) begin
      tmoCount <= tmoCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrFlag <= 1'b0;
    end else if (stb.ovrClr) begin
      ovrFlag <= 1'b0;
    end else if (stb.ovrSet) begin
      ovrFlag <= 1'b1;
    end
  end

  // R3: receive level never exceeds capacity
  assert_rx_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

  // R10: transmit level never exceeds capacity
  assert_tx_bounded_R10: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(DEPTH));

endmodule

// File: rtl/uart_flags_ctrl.sv
module uart_flags_ctrl
  import uart_flags_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4,
  parameter int CNT_W         = 5,
  parameter int TMO_W         = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxFlush,
  input  logic             txFlush,
  input  logic [1:0]       trigSel,
  input  logic [1:0]       wordLen,
  input  logic             parityEn,
  input  logic [1:0]       stopSel,
  input  logic             tick16,
  input  logic             stopCentre,
  input  logic             dmaMode,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txCount,
  input  logic [TMO_W-1:0] tmoCount,
  input  logic             ovrFlag,
  output flag_strobes_t    stb,
  output logic             rxIrq,
  output logic             dataReady,
  output logic             rxTimeout,
  output logic             overrun,
  output logic             rxRdyN,
  output logic             txRdyN
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             rxEmpty;
  logic             rxFull;
  logic             txEmpty;
  logic             txFull;
  logic             rxPopOk;
  logic             rxPushOk;
  logic             txPopOk;
  logic             txPushOk;
  logic             rxAtTrig;
  logic             tmoHit;
  logic             rxHold;
  logic [CNT_W-1:0] trigCnt;
  logic [TMO_W-1:0] tmoLimit;

  always_comb begin
    rxEmpty  = (rxCount == '0);
    rxFull   = (rxCount == FULL_CNT);
    txEmpty  = (txCount == '0);
    txFull   = (txCount == FULL_CNT);
    trigCnt  = CNT_W'(trigLevel(trigSel));
    tmoLimit = TMO_W'(TMO_CHARS * charTicks(wordLen, parityEn, stopSel, TICKS_PER_BIT));
    rxAtTrig = (rxCount >= trigCnt);
    tmoHit   = !rxEmpty && (tmoCount >= tmoLimit);
  end

  always_comb begin
    rxPopOk  = rxPop && !rxEmpty;
    rxPushOk = rxPush && (!rxFull || rxPopOk);
    txPopOk  = txPop && !txEmpty;
    txPushOk = txPush && (!txFull || txPopOk);

    stb         = '0;
    stb.rxClr   = rxFlush;
    stb.rxInc   = rxPushOk;
    stb.rxDec   = rxPopOk;
    stb.ovrClr  = rxFlush;
    stb.ovrSet  = rxPush && !rxPushOk;
    stb.txClr   = txFlush;
    stb.txInc   = txPushOk;
    stb.txDec   = txPopOk;
    stb.tmoClr  = stopCentre || rxPop || rxFlush || rxEmpty;
    stb.tmoStep = tick16 && (tmoCount < tmoLimit);
  end

  // Block-mode receive latch: set by threshold or timeout, dropped on empty
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold <= 1'b0;
    end else if (rxFlush || rxEmpty) begin
      rxHold <= 1'b0;
    end else if (rxAtTrig || tmoHit) begin
      rxHold <= 1'b1;
    end
  end

  always_comb begin
    rxIrq     = rxAtTrig;
    dataReady = !rxEmpty;
    rxTimeout = tmoHit;
    overrun   = ovrFlag;
    if (dmaMode) begin
      rxRdyN = !(!rxEmpty && (rxHold || rxAtTrig || tmoHit));
      txRdyN = txFull;
    end else begin
      rxRdyN = rxEmpty;
      txRdyN = !txEmpty;
    end
  end

  // R3: a lost push leaves the queue full and raises overrun
  assert_overrun_keeps_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull && !rxPop && !rxFlush) |=> (rxCount == FULL_CNT) && ovrFlag);

  // R4: push and pop together on a non-empty queue hold the level
  assert_push_pop_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxPop && !rxEmpty && !rxFlush) |=> $stable(rxCount));

  // R6: a host read restarts the gap timer
  assert_pop_restarts_timer_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> (tmoCount == '0));

  // R11: transmit flush empties the transmit queue
  assert_tx_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> (txCount == '0));

  // R11: receive flush empties the receive queue and clears overrun
  assert_rx_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxFlush |=> (rxCount == '0) && !ovrFlag);

endmodule

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags
  import uart_flags_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPush,
  input  logic       rxPop,
  input  logic       txPush,
  input  logic       txPop,
  input  logic       rxFlush,
  input  logic       txFlush,
  input  logic [1:0] trigSel,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic [1:0] stopSel,
  input  logic       tick16,
  input  logic       stopCentre,
  input  logic       dmaMode,
  output logic       rxIrq,
  output logic       dataReady,
  output logic       rxTimeout,
  output logic       overrun,
  output logic       rxRdyN,
  output logic       txRdyN
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  // longest frame: start + 8 data + parity + 2 stop bits
  localparam int TMO_W = $clog2(TMO_CHARS * TICKS_PER_BIT * 12 + 1);

  flag_strobes_t    stb;
  logic [CNT_W-1:0] rxCount;
  logic [CNT_W-1:0] txCount;
  logic [TMO_W-1:0] tmoCount;
  logic             ovrFlag;

  uart_flags_ctrl #(
    .DEPTH(DEPTH), .TICKS_PER_BIT(TICKS_PER_BIT), .TMO_CHARS(TMO_CHARS),
    .CNT_W(CNT_W), .TMO_W(TMO_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rxPush(rxPush), .rxPop(rxPop), .txPush(txPush), .txPop(txPop),
    .rxFlush(rxFlush), .txFlush(txFlush), .trigSel(trigSel),
    .wordLen(wordLen), .parityEn(parityEn), .stopSel(stopSel),
    .tick16(tick16), .stopCentre(stopCentre), .dmaMode(dmaMode),
    .rxCount(rxCount), .txCount(txCount), .tmoCount(tmoCount), .ovrFlag(ovrFlag),
    .stb(stb),
    .rxIrq(rxIrq), .dataReady(dataReady), .rxTimeout(rxTimeout),
    .overrun(overrun), .rxRdyN(rxRdyN), .txRdyN(txRdyN)
  );

  uart_flags_dp #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .TMO_W(TMO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rxCount(rxCount), .txCount(txCount), .tmoCount(tmoCount), .ovrFlag(ovrFlag)
  );

endmodule

// File: tb/sim_uart_fifo_flags.sv
module sim_uart_fifo_flags;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic       rxFlush = 1'b0, txFlush = 1'b0;
  logic [1:0] trigSel = 2'b00, wordLen = 2'b00, stopSel = 2'b00;
  logic       parityEn = 1'b0, tick16 = 1'b0, stopCentre = 1'b0, dmaMode = 1'b0;
  logic       rxIrq, dataReady, rxTimeout, overrun, rxRdyN, txRdyN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_flags u0 (
    .clk(clk), .rstN(rstN),
    .rxPush(rxPush), .rxPop(rxPop), .txPush(txPush), .txPop(txPop),
    .rxFlush(rxFlush), .txFlush(txFlush), .trigSel(trigSel),
    .wordLen(wordLen), .parityEn(parityEn), .stopSel(stopSel),
    .tick16(tick16), .stopCentre(stopCentre), .dmaMode(dmaMode),
    .rxIrq(rxIrq), .dataReady(dataReady), .rxTimeout(rxTimeout),
    .overrun(overrun), .rxRdyN(rxRdyN), .txRdyN(txRdyN)
  );

  // vector: [6:5] op (0 idle,1 push,2 pop,3 both), [4:3] trigSel,
  //         [2] rxIrq, [1] dataReady, [0] rxRdyN (mode 0)
  localparam int NVEC = 14;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b01_01_010, // R1 level 1, threshold 4
    7'b01_01_010, // level 2
    7'b01_01_010, // level 3
    7'b01_01_110, // R1 level 4 reaches threshold
    7'b11_01_110, // R4 push+pop keeps 4
    7'b10_01_010, // R1 level 3 below threshold
    7'b00_00_110, // R1 threshold 1
    7'b00_10_010, // R1 threshold 8
    7'b10_10_010, // level 2
    7'b10_10_010, // level 1
    7'b10_10_001, // R2 R7 empty
    7'b10_10_001, // R4 pop on empty ignored
    7'b11_00_110, // R4 both on empty acts as push
    7'b10_00_001  // R7 empty again
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic pushRx(input logic sc);
    rxPush = 1'b1; stopCentre = sc;
    cyc();
    rxPush = 1'b0; stopCentre = 1'b0;
  endtask

  task automatic popRx();
    rxPop = 1'b1;
    cyc();
    rxPop = 1'b0;
  endtask

  task automatic flushRx();
    rxFlush = 1'b1;
    cyc();
    rxFlush = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tmoCase(input logic [1:0] wl, input logic par, input logic [1:0] st,
                         input int limit, input string tag);
    flushRx();
    wordLen = wl; parityEn = par; stopSel = st;
    tick16 = 1'b1;
    pushRx(1'b1);
    repeat (limit - 1) cyc();
    chk({tag, " before limit"}, rxTimeout, 1'b0);
    cyc();
    chk({tag, " at limit"}, rxTimeout, 1'b1);
    tick16 = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rxIrq", rxIrq, 1'b0);
    chk("R12 dataReady", dataReady, 1'b0);
    chk("R12 rxTimeout", rxTimeout, 1'b0);
    chk("R12 overrun", overrun, 1'b0);
    chk("R12 rxRdyN", rxRdyN, 1'b1);
    chk("R12 txRdyN", txRdyN, 1'b0);
    rstN = 1'b1;
    cyc();

    // table walk: R1 R2 R4 R7
    for (int i = 0; i < NVEC; i++) begin
      trigSel = VEC[i][4:3];
      rxPush  = VEC[i][5];
      rxPop   = VEC[i][6];
      cyc();
      chk($sformatf("R1 rxIrq vec %0d", i), rxIrq, VEC[i][2]);
      chk($sformatf("R2 dataReady vec %0d", i), dataReady, VEC[i][1]);
      chk($sformatf("R7 rxRdyN vec %0d", i), rxRdyN, VEC[i][0]);
      rxPush = 1'b0; rxPop = 1'b0;
    end

    // R1 threshold 14, then R3 overrun at full
    trigSel = 2'b11;
    repeat (13) pushRx(1'b0);
    chk("R1 level 13 below 14", rxIrq, 1'b0);
    pushRx(1'b0);
    chk("R1 level 14", rxIrq, 1'b1);
    pushRx(1'b0); pushRx(1'b0);
    chk("R3 full no overrun yet", overrun, 1'b0);
    pushRx(1'b0);
    chk("R3 overrun set", overrun, 1'b1);
    repeat (15) popRx();
    chk("R3 one left after 15 pops", dataReady, 1'b1);
    chk("R3 overrun sticky", overrun, 1'b1);
    popRx();
    chk("R3 level was 16", dataReady, 1'b0);

    // R11 flushes
    pushRx(1'b0);
    txPush = 1'b1; cyc(); txPush = 1'b0;
    chk("R9 txRdyN high with data", txRdyN, 1'b1);
    txFlush = 1'b1; cyc(); txFlush = 1'b0;
    chk("R11 tx flush empties tx", txRdyN, 1'b0);
    chk("R11 tx flush keeps rx", dataReady, 1'b1);
    chk("R11 overrun before rx flush", overrun, 1'b1);
    flushRx();
    chk("R11 rx flush empties rx", dataReady, 1'b0);
    chk("R11 rx flush clears overrun", overrun, 1'b0);

    // R9 per-character transmit strobe
    txPush = 1'b1; cyc(); txPush = 1'b0;
    chk("R9 one tx char", txRdyN, 1'b1);
    txPop = 1'b1; cyc(); txPop = 1'b0;
    chk("R9 tx empty", txRdyN, 1'b0);

    // R10 block transmit strobe
    dmaMode = 1'b1;
    txPush = 1'b1; repeat (15) cyc(); txPush = 1'b0;
    chk("R10 15 used", txRdyN, 1'b0);
    txPush = 1'b1; cyc();
    chk("R10 full", txRdyN, 1'b1);
    cyc(); txPush = 1'b0;
    txPop = 1'b1; cyc(); txPop = 1'b0;
    chk("R10 push into full ignored", txRdyN, 1'b0);
    txFlush = 1'b1; cyc(); txFlush = 1'b0;

    // R8 block receive strobe, threshold 4
    trigSel = 2'b01;
    pushRx(1'b0);
    chk("R8 below threshold", rxRdyN, 1'b1);
    repeat (3) pushRx(1'b0);
    chk("R8 threshold", rxRdyN, 1'b0);
    repeat (2) popRx();
    chk("R8 sticky below threshold", rxRdyN, 1'b0);
    repeat (2) popRx();
    chk("R8 released on empty", rxRdyN, 1'b1);

    // R8 timeout as cause
    tick16 = 1'b1;
    pushRx(1'b1);
    repeat (447) cyc();
    chk("R8 before timeout", rxRdyN, 1'b1);
    cyc();
    chk("R8 timeout lowers", rxRdyN, 1'b0);
    stopCentre = 1'b1; cyc(); stopCentre = 1'b0;
    chk("R6 stopCentre restarts", rxTimeout, 1'b0);
    chk("R8 sticky after timeout", rxRdyN, 1'b0);
    tick16 = 1'b0;
    popRx();
    chk("R8 empty releases", rxRdyN, 1'b1);
    dmaMode = 1'b0;

    // R5 formats
    tmoCase(2'b00, 1'b0, 2'b00, 448, "R5 5N1");
    tmoCase(2'b11, 1'b1, 2'b01, 736, "R5 8P1.5");
    tmoCase(2'b10, 1'b1, 2'b10, 704, "R5 7P2");

    // R6 restart on pop, none when empty
    flushRx();
    wordLen = 2'b00; parityEn = 1'b0; stopSel = 2'b00;
    tick16 = 1'b1;
    pushRx(1'b1); pushRx(1'b1);
    repeat (200) cyc();
    popRx();
    repeat (447) cyc();
    chk("R6 pop restart before", rxTimeout, 1'b0);
    cyc();
    chk("R6 pop restart at limit", rxTimeout, 1'b1);
    popRx();
    repeat (1000) cyc();
    chk("R6 no timeout when empty", rxTimeout, 1'b0);
    tick16 = 1'b0;

    done = 1'b1;
    finishRun();
  end

endmodule